// File: doc/BRIEF.md
# Spare-Area Burst Address Mapper

This block turns a request on the out-of-band (spare) area of a NAND page into a series of address bursts across eight separate spare buffer windows of 64 bytes each. The request gives a start offset and a byte length, both counted linearly from the start of the spare area. It also carries the page geometry: the spare size in bytes, and the base-2 logarithm of the number of 512-byte chunks in a page. A page of 2^k × 512 bytes is split into 2^k chunks. Each chunk's share of the spare area sits at the bottom of its own window.

Each chunk's share is the spare size divided by the chunk count, forced down to an even number. The bytes left over after the even shares are assigned all go to the last chunk's window. Bursts therefore do not all have the same length.

A request is taken with a valid/ready handshake. The block then presents one burst per cycle as a buffer address and a length, and it holds each burst until the consumer accepts it. After the final burst it pulses `done`. The data transfer is not part of this block.

Top module: `spb_mapper`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `burst_valid` is 0 and `done` is 0.
- R2: The chunk count is 2^`req_pg_lg`, where `req_pg_lg` ranges from 0 to 3. The per-window share is (`req_spare` >> `req_pg_lg`) with bit 0 cleared.
- R3: The window index of a byte is its spare offset divided by the share, clamped to the last chunk (chunk count − 1). Its offset inside the window is the spare offset minus index × share.
- R4: `burst_addr` = 0x1000 + index × 0x40 + offset inside the window.
- R5: `burst_len` is the smaller of the bytes still requested and the bytes left in the window. Bytes left in the window are share − in-window offset, except in the last chunk's window, where they run to the 64-byte window end.
- R6: Bursts advance in ascending address order, with one burst for each window touched. Their lengths add up to the requested length.
- R7: While `burst_valid` is 1 and `burst_ready` is 0, the burst stays presented with unchanged address and length.
- R8: `done` is a one-cycle pulse in the cycle after the final burst is accepted. No burst is presented while `done` is high, and `req_ready` is 0 during that cycle.
- R9: A request with `req_len` = 0 produces no burst, and `done` rises in the cycle after the request is accepted.
- R10: `req_ready` is 0 while a request is being served. A `req_valid` raised during that time is ignored, and the bursts in flight are unchanged.
- R11: No burst crosses the end of a 64-byte window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_offset | input | 9 | Start offset in the spare area |
| req_len | input | 9 | Bytes requested |
| req_pg_lg | input | 2 | log2 of the number of 512-byte chunks per page |
| req_spare | input | 9 | Spare area size in bytes |
| burst_valid | output | 1 | Burst presented |
| burst_ready | input | 1 | Consumer takes the burst |
| burst_addr | output | 13 | Buffer byte address of the burst |
| burst_len | output | 7 | Burst length in bytes |
| done | output | 1 | Request finished pulse |

## Verification
The properties assume that every request stays inside the spare area, so that offset + length does not exceed the spare size. They also assume that `req_pg_lg` does not exceed 3, and that the last window's share plus the leftover bytes fits within 64 bytes. Every stimulus geometry is a realistic spare layout that meets these limits: 16 bytes for one chunk, 30 for two, 64 for four, and 218 for eight. Each request's range lies inside its spare area. Within those limits the stimulus covers odd shares that round down, spill bytes in the last window, and zero length. It also covers consumer stalls in the middle of a request and request pulses raised while the block is busy.

// File: rtl/spb_pkg.sv
package spb_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } spb_state_e;

endpackage

// File: rtl/spb_locate.sv
// Finds which spare window holds a spare offset, the offset inside it,
// and how many bytes of that window are still usable.
module spb_locate #(
    parameter int NUM_BUF   = 8,
    parameter int WIN_BYTES = 64,
    parameter int SPW       = 9,
    parameter int IDXW      = $clog2(NUM_BUF),
    parameter int LGW       = $clog2(IDXW + 1)
) (
    input  logic [SPW-1:0]  off,
    input  logic [SPW-1:0]  spare,
    input  logic [LGW-1:0]  lg,
    output logic [IDXW-1:0] idx,
    output logic [SPW-1:0]  in_off,
    output logic [SPW-1:0]  avail
);
    localparam int PW = SPW + IDXW;

    logic [SPW-1:0]         shifted;
    logic [SPW-1:0]         share;
    logic [IDXW-1:0]        last_idx;
    logic [NUM_BUF-1:1]     past_k;
    logic [SPW-1:0]         limit;

    assign shifted  = spare >> lg;
    assign share    = {shifted[SPW-1:1], 1'b0};
    assign last_idx = IDXW'((32'd1 << lg) - 32'd1);

    // one threshold comparator per window boundary
    for (genvar k = 1; k < NUM_BUF; k++) begin : g_thr
        assign past_k[k] = (IDXW'(k) <= last_idx) &&
                           (PW'(off) >= PW'(k) * PW'(share));
    end

    always_comb begin
        idx = '0;
        for (int i = 1; i < NUM_BUF; i++) begin
            if (past_k[i]) idx = IDXW'(i);
        end
    end

    assign in_off = off - SPW'(PW'(idx) * PW'(share));
    assign limit  = (idx == last_idx) ? SPW'(WIN_BYTES) : share;
    assign avail  = (in_off >= limit) ? '0 : (limit - in_off);

endmodule

// File: rtl/spb_burst.sv
// Forms the buffer address and clipped length of one burst.
module spb_burst #(
    parameter int NUM_BUF    = 8,
    parameter int WIN_BYTES  = 64,
    parameter int SPARE_BASE = 'h1000,
    parameter int SPW        = 9,
    parameter int ADDR_W     = 13,
    parameter int IDXW       = $clog2(NUM_BUF),
    parameter int WINW       = $clog2(WIN_BYTES) + 1
) (
    input  logic [IDXW-1:0]   idx,
    input  logic [SPW-1:0]    in_off,
    input  logic [SPW-1:0]    avail,
    input  logic [SPW-1:0]    rem,
    output logic [ADDR_W-1:0] addr,
    output logic [WINW-1:0]   blen
);
    logic [SPW-1:0] smaller;

    assign smaller = (rem < avail) ? rem : avail;
    assign blen    = (smaller > SPW'(WIN_BYTES)) ? WINW'(WIN_BYTES) : WINW'(smaller);
    assign addr    = ADDR_W'(SPARE_BASE) + ADDR_W'(idx) * ADDR_W'(WIN_BYTES) + ADDR_W'(in_off);

endmodule

// File: rtl/spb_mapper.sv
module spb_mapper #(
    parameter int NUM_BUF    = 8,
    parameter int WIN_BYTES  = 64,
    parameter int SPARE_BASE = 'h1000,
    parameter int OFS_W      = 8,
    parameter int ADDR_W     = 13,
    localparam int SPW       = OFS_W + 1,
    localparam int IDXW      = $clog2(NUM_BUF),
    localparam int LGW       = $clog2(IDXW + 1),
    localparam int WINW      = $clog2(WIN_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SPW-1:0]    req_offset,
    input  logic [SPW-1:0]    req_len,
    input  logic [LGW-1:0]    req_pg_lg,
    input  logic [SPW-1:0]    req_spare,
    output logic              burst_valid,
    input  logic              burst_ready,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [WINW-1:0]   burst_len,
    output logic              done
);
    import spb_pkg::*;

    typedef struct packed {
        spb_state_e     st;
        logic [SPW-1:0] off;
        logic [SPW-1:0] rem;
        logic [SPW-1:0] spare;
        logic [LGW-1:0] lg;
        logic           done;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDXW-1:0] cur_idx;
    logic [SPW-1:0]  cur_in_off;
    logic [SPW-1:0]  cur_avail;
    logic [WINW-1:0] cur_blen;
    logic            burst_fire;

    spb_locate #(
        .NUM_BUF  (NUM_BUF),
        .WIN_BYTES(WIN_BYTES),
        .SPW      (SPW),
        .IDXW     (IDXW),
        .LGW      (LGW)
    ) u_locate (
        .off   (r_q.off),
        .spare (r_q.spare),
        .lg    (r_q.lg),
        .idx   (cur_idx),
        .in_off(cur_in_off),
        .avail (cur_avail)
    );

    spb_burst #(
        .NUM_BUF   (NUM_BUF),
        .WIN_BYTES (WIN_BYTES),
        .SPARE_BASE(SPARE_BASE),
        .SPW       (SPW),
        .ADDR_W    (ADDR_W),
        .IDXW      (IDXW),
        .WINW      (WINW)
    ) u_burst (
        .idx   (cur_idx),
        .in_off(cur_in_off),
        .avail (cur_avail),
        .rem   (r_q.rem),
        .addr  (burst_addr),
        .blen  (cur_blen)
    );

    assign req_ready   = (r_q.st == ST_IDLE) && !r_q.done;
    assign burst_valid = (r_q.st == ST_BUSY) && (cur_blen != '0);
    assign burst_len   = cur_blen;
    assign done        = r_q.done;
    assign burst_fire  = burst_valid && burst_ready;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    r_d.off   = req_offset;
                    r_d.rem   = req_len;
                    r_d.spare = req_spare;
                    r_d.lg    = req_pg_lg;
                    if (req_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_BUSY;
                    end
                end
            end
            ST_BUSY: begin
                if (cur_blen == '0) begin
                    // nothing addressable is left: close the request
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (burst_fire) begin
                    r_d.off = r_q.off + SPW'(cur_blen);
                    r_d.rem = r_q.rem - SPW'(cur_blen);
                    if (r_q.rem == SPW'(cur_blen)) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, off: '0, rem: '0, spare: '0, lg: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/spb_mapper_chk.sv
module spb_mapper_chk #(
    parameter int NUM_BUF    = 8,
    parameter int WIN_BYTES  = 64,
    parameter int SPARE_BASE = 'h1000,
    parameter int ADDR_W     = 13,
    localparam int WINW      = $clog2(WIN_BYTES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              burst_valid,
    input logic              burst_ready,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [WINW-1:0]   burst_len,
    input logic              done
);
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr) && $stable(burst_len)); // R7

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len != '0) && (32'(burst_len) <= WIN_BYTES)); // R5

    AST_ADDR_IN_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (32'(burst_addr) >= SPARE_BASE) &&
                        (32'(burst_addr) + 32'(burst_len) <= SPARE_BASE + NUM_BUF * WIN_BYTES)); // R4

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> ((32'(burst_addr) - SPARE_BASE) % WIN_BYTES) + 32'(burst_len) <= WIN_BYTES); // R11

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && burst_ready |=> !burst_valid || (burst_addr > $past(burst_addr))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !burst_valid && !req_ready); // R8

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> !req_ready); // R10

endmodule

bind spb_mapper spb_mapper_chk #(
    .NUM_BUF   (NUM_BUF),
    .WIN_BYTES (WIN_BYTES),
    .SPARE_BASE(SPARE_BASE),
    .ADDR_W    (ADDR_W)
) u_spb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .burst_valid(burst_valid),
    .burst_ready(burst_ready),
    .burst_addr (burst_addr),
    .burst_len  (burst_len),
    .done       (done)
);

// File: tb/spb_mapper_bench.sv
module spb_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [8:0]  req_offset;
    logic [8:0]  req_len;
    logic [1:0]  req_pg_lg;
    logic [8:0]  req_spare;
    logic        burst_valid;
    logic        burst_ready;
    logic [12:0] burst_addr;
    logic [6:0]  burst_len;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spb_mapper u_spb_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_offset (req_offset),
        .req_len    (req_len),
        .req_pg_lg  (req_pg_lg),
        .req_spare  (req_spare),
        .burst_valid(burst_valid),
        .burst_ready(burst_ready),
        .burst_addr (burst_addr),
        .burst_len  (burst_len),
        .done       (done)
    );

    typedef struct packed {
        int off;
        int len;
        int lg;
        int spare;
        int nb;
        int a0;
        int l0;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{0,   64,  2, 64,  4, 'h1000, 16},
        '{10,  20,  2, 64,  2, 'h100A, 6},
        '{200, 18,  3, 218, 1, 'h11D2, 18},
        '{170, 48,  3, 218, 2, 'h118E, 12},
        '{5,   11,  0, 16,  1, 'h1005, 11},
        '{12,  18,  1, 30,  2, 'h100C, 2},
        '{0,   0,   2, 64,  0, 0,      0},
        '{0,   218, 3, 218, 8, 'h1000, 26}
    };

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    // expected burst from the mapping rules (R2, R3, R4, R5)
    function automatic void model(input int off, input int rem, input int lg, input int spare,
                                  output int addr, output int blen);
        int share, last, idx, o, avail;
        share = (spare >> lg) & ~1;
        last  = (1 << lg) - 1;
        idx   = 0;
        for (int k = 1; k <= last; k++) if (off >= k * share) idx = k;
        o     = off - idx * share;
        avail = (idx == last) ? (64 - o) : (share - o);
        blen  = (rem < avail) ? rem : avail;
        addr  = 'h1000 + idx * 64 + o;
    endfunction

    task automatic run_case(input vec_t v, input int stall_at, input bit poke);
        int m_off, m_rem, seen, ea, el, stall_left, prev_a;
        bit pend_done, stalled;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "req_ready before request", req_ready, 1);
        req_valid  = 1'b1;
        req_offset = 9'(v.off);
        req_len    = 9'(v.len);
        req_pg_lg  = 2'(v.lg);
        req_spare  = 9'(v.spare);
        burst_ready = 1'b1;
        m_off = v.off; m_rem = v.len; seen = 0;
        pend_done = (v.len == 0);
        stall_left = 3; stalled = 0; prev_a = 0;
        for (int cyc = 0; cyc < 100; cyc++) begin
            @(negedge clk);
            if (poke) begin
                req_valid  = 1'b1;
                req_offset = 9'd1;
                req_len    = 9'd3;
                req_pg_lg  = 2'd0;
                req_spare  = 9'd16;
            end else begin
                req_valid = 1'b0;
            end
            if (pend_done) begin
                req_valid = 1'b0;
                check(done == 1'b1, (v.len == 0) ? "R9" : "R8", "done after last", done, 1);
                check(burst_valid == 1'b0, (v.len == 0) ? "R9" : "R8", "no burst with done", burst_valid, 0);
                break;
            end
            check(done == 1'b0, "R8", "early done", done, 0);
            if (poke) check(req_ready == 1'b0, "R10", "req_ready while busy", req_ready, 0);
            if (stalled) check(burst_valid && (burst_addr == 13'(prev_a)), "R7", "held addr", burst_addr, prev_a);
            stalled = 0;
            if (burst_valid) begin
                model(m_off, m_rem, v.lg, v.spare, ea, el);
                if (seen == 0) begin
                    check(burst_addr == 13'(v.a0), "R3", "first addr", burst_addr, v.a0);
                    check(burst_len == 7'(v.l0), "R2", "first len", burst_len, v.l0);
                end
                check(burst_addr == 13'(ea), "R4", "burst addr", burst_addr, ea);
                check(burst_len == 7'(el), "R5", "burst len", burst_len, el);
                if (seen == stall_at && stall_left > 0) begin
                    burst_ready = 1'b0;
                    stall_left--;
                    stalled = 1;
                    prev_a = int'(burst_addr);
                end else begin
                    burst_ready = 1'b1;
                    m_off += el;
                    m_rem -= el;
                    seen++;
                    if (m_rem <= 0) pend_done = 1;
                end
            end
        end
        req_valid = 1'b0;
        burst_ready = 1'b1;
        check(seen == v.nb, "R6", "burst count", seen, v.nb);
        check(m_rem == 0, "R6", "bytes covered", m_rem, 0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_offset = '0;
        req_len = '0;
        req_pg_lg = '0;
        req_spare = '0;
        burst_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        check(burst_valid == 1'b0, "R1", "burst_valid in reset", burst_valid, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !burst_valid && !done, "R1", "idle after reset",
              {req_ready, burst_valid, done}, 3'b100);

        // table walk
        for (int i = 0; i < NVEC; i++) run_case(VECS[i], -1, 1'b0);

        // R7: consumer stalls mid-request
        run_case(VECS[0], 1, 1'b0);
        run_case(VECS[3], 0, 1'b0);
        // R10: request pulses while busy are ignored
        run_case(VECS[7], -1, 1'b1);
        run_case(VECS[5], 1, 1'b1);
        // R9 again right after a busy request
        run_case(VECS[6], -1, 1'b0);

        repeat (3) @(negedge clk);
        check(!burst_valid && !done && req_ready, "R10", "quiet after poked runs",
              {req_ready, burst_valid, done}, 3'b100);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule